// File: doc/BRIEF.md
# Sliding Window Cluster Finder

This block finds compact energy clusters in one tile of a calorimeter trigger. Each bunch crossing it receives a square patch of trigger-tower transverse energies. It forms a two-by-two window sum at every anchor in the patch. It keeps a window as a cluster seed only where that sum beats all eight surrounding window sums. For each seed in the central output area it then adds up a four-by-four cluster energy, checks that the seed window holds a large enough share of that energy, and reports which of seven programmable thresholds the cluster clears.

The default tile takes 9x9 towers of 8 bits and reports a 4x4 grid of 3-bit codes. Code 0 means no seed, or a seed that is not isolated, or a seed that clears no threshold. The outer towers of the patch are used only as context for the neighbour comparison and the cluster ring. The threshold set and the isolation ratio are sampled together with the patch. A crossing is therefore judged with the configuration that was present when it arrived.

Top module: `swc_cluster_finder`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid` and every bit of `res_codes` are cleared at that edge.
- R2: A patch sampled with `in_valid` high at edge N sets `res_valid` high after edge N+1 with that patch's codes. At other edges `res_valid` is low and `res_codes` keeps its last value.
- R3: Tower (row r, column c) sits at `towers[(r*9+c)*8 +: 8]`. The seed window of output position (i, j) is the 2x2 block with rows i+2..i+3 and columns j+2..j+3.
- R4: A position is a seed only if its window sum beats the eight windows whose anchors differ by at most one row and one column. It must be strictly greater than the windows in the row above, and than the window directly to its left. It must be greater than or equal to the window directly to its right and the windows in the row below. A flat plateau therefore yields no seed at any position.
- R5: No two output positions that touch horizontally, vertically or diagonally both carry a nonzero code in the same result.
- R6: The cluster energy of position (i, j) is the sum of the 4x4 towers with rows i+1..i+4 and columns j+1..j+4.
- R7: A seed is isolated when window_sum * `iso_den` > cluster_energy * `iso_num`. A seed that is not isolated reports code 0.
- R8: Threshold k (k = 1..7) is `thr[(k-1)*12 +: 12]`. An isolated seed reports the largest k whose threshold is at most its cluster energy, and 0 if there is none. The thresholds do not need to be in any order.
- R9: The code of position (i, j) is `res_codes[i*12 + j*3 +: 3]`, so each output row forms one 12-bit word with column 0 in bits 2..0.
- R10: All sums are exact for full-scale 8-bit towers. A cluster energy above 2047 still compares correctly against a 12-bit threshold.
- R11: Changes to `thr`, `iso_num` or `iso_den` after the edge that samples a patch do not alter that patch's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Patch present this crossing |
| towers | input | 648 | 9x9 tower energies, 8 bits each, row-major |
| thr | input | 84 | Seven 12-bit cluster thresholds |
| iso_num | input | 4 | Isolation ratio numerator |
| iso_den | input | 4 | Isolation ratio denominator |
| res_valid | output | 1 | Result codes are new this cycle |
| res_codes | output | 48 | 4x4 grid of 3-bit threshold codes |

## Verification
On every cycle the assertions check four things. They check the two-cycle valid latency in both directions, and that the codes hold while no result is valid. They check the clearing on reset. They check that no two touching output positions report seeds at once, which is the visible effect of the asymmetric tie rule. Only the bench scenarios can show the arithmetic content of the codes. This covers where the seed lands for a lone tower at each of the 81 sites, and that a plateau yields nothing. It also covers the cluster ring, the ratio cut under several numerator and denominator pairs, unordered thresholds, full-scale sums, and that the configuration is captured along with the patch.

// File: rtl/swc_pkg.sv
package swc_pkg;

  // Neighbour windows around a seed, in raster order with the centre removed.
  localparam int unsigned NBR_N     = 8;
  // The first NBR_EARLY neighbours precede the seed in raster order.
  localparam int unsigned NBR_EARLY = 4;

  typedef enum logic {
    CMP_STRICT = 1'b0,
    CMP_INCL   = 1'b1
  } cmp_mode_e;

  function automatic int nbr_dr(input int k);
    int p;
    p = (k < int'(NBR_EARLY)) ? k : k + 1;
    return (p / 3) - 1;
  endfunction

  function automatic int nbr_dc(input int k);
    int p;
    p = (k < int'(NBR_EARLY)) ? k : k + 1;
    return (p % 3) - 1;
  endfunction

  function automatic cmp_mode_e nbr_mode(input int k);
    return (k < int'(NBR_EARLY)) ? CMP_STRICT : CMP_INCL;
  endfunction

endpackage

// File: rtl/swc_roi_sum.sv
module swc_roi_sum #(
  parameter int unsigned PATCH = 9,
  parameter int unsigned ET_W  = 8,
  localparam int unsigned ROI_N  = PATCH - 1,
  localparam int unsigned SUM2_W = ET_W + 2
) (
  input  logic [PATCH*PATCH*ET_W-1:0]   towers_i,
  output logic [ROI_N*ROI_N*SUM2_W-1:0] roi_o
);

  for (genvar r = 0; r < ROI_N; r++) begin : g_row
    for (genvar c = 0; c < ROI_N; c++) begin : g_col
      localparam int unsigned B00 = (r*PATCH + c) * ET_W;
      localparam int unsigned B01 = (r*PATCH + c + 1) * ET_W;
      localparam int unsigned B10 = ((r+1)*PATCH + c) * ET_W;
      localparam int unsigned B11 = ((r+1)*PATCH + c + 1) * ET_W;
      assign roi_o[(r*ROI_N + c)*SUM2_W +: SUM2_W] =
          SUM2_W'(towers_i[B00 +: ET_W]) + SUM2_W'(towers_i[B01 +: ET_W]) +
          SUM2_W'(towers_i[B10 +: ET_W]) + SUM2_W'(towers_i[B11 +: ET_W]);
    end
  end

endmodule

// File: rtl/swc_area_sum.sv
module swc_area_sum #(
  parameter int unsigned PATCH = 9,
  parameter int unsigned OUT_N = 4,
  parameter int unsigned ET_W  = 8,
  localparam int unsigned AREA   = 4,
  localparam int unsigned SUM4_W = ET_W + $clog2(AREA*AREA)
) (
  input  logic [PATCH*PATCH*ET_W-1:0]   towers_i,
  output logic [OUT_N*OUT_N*SUM4_W-1:0] area_o
);

  for (genvar i = 0; i < OUT_N; i++) begin : g_row
    for (genvar j = 0; j < OUT_N; j++) begin : g_col
      logic [SUM4_W-1:0] acc;
      always_comb begin
        acc = '0;
        for (int dr = 0; dr < int'(AREA); dr++) begin
          for (int dc = 0; dc < int'(AREA); dc++) begin
            acc = acc + SUM4_W'(towers_i[((i+1+dr)*int'(PATCH) + (j+1+dc))*int'(ET_W) +: ET_W]);
          end
        end
      end
      assign area_o[(i*OUT_N + j)*SUM4_W +: SUM4_W] = acc;
    end
  end

endmodule

// File: rtl/swc_peak_judge.sv
module swc_peak_judge #(
  parameter int unsigned SUM2_W  = 10,
  parameter int unsigned SUM4_W  = 12,
  parameter int unsigned N_THR   = 7,
  parameter int unsigned RATIO_W = 4,
  localparam int unsigned CODE_W = $clog2(N_THR + 1),
  localparam int unsigned PROD_W = SUM4_W + RATIO_W
) (
  input  logic [SUM2_W-1:0]                cand_i,
  input  logic [swc_pkg::NBR_N*SUM2_W-1:0] nbr_i,
  input  logic [SUM4_W-1:0]                clus_i,
  input  logic [N_THR*SUM4_W-1:0]          thr_i,
  input  logic [RATIO_W-1:0]               num_i,
  input  logic [RATIO_W-1:0]               den_i,
  output logic [CODE_W-1:0]                code_o
);

  logic [swc_pkg::NBR_N-1:0] beat;

  for (genvar k = 0; k < swc_pkg::NBR_N; k++) begin : g_nbr
    if (swc_pkg::nbr_mode(k) == swc_pkg::CMP_STRICT) begin : g_strict
      assign beat[k] = cand_i >  nbr_i[k*SUM2_W +: SUM2_W];
    end else begin : g_incl
      assign beat[k] = cand_i >= nbr_i[k*SUM2_W +: SUM2_W];
    end
  end

  logic              is_peak;
  logic              is_iso;
  logic [PROD_W-1:0] core_scaled;
  logic [PROD_W-1:0] area_scaled;
  logic [CODE_W-1:0] level;

  assign is_peak     = &beat;
  assign core_scaled = PROD_W'(cand_i) * PROD_W'(den_i);
  assign area_scaled = PROD_W'(clus_i) * PROD_W'(num_i);
  assign is_iso      = core_scaled > area_scaled;

  always_comb begin
    level = '0;
    for (int k = 0; k < int'(N_THR); k++) begin
      if (clus_i >= thr_i[k*SUM4_W +: SUM4_W]) level = CODE_W'(k + 1);
    end
  end

  assign code_o = (is_peak && is_iso) ? level : '0;

endmodule

// File: rtl/swc_cluster_finder.sv
module swc_cluster_finder #(
  parameter int unsigned OUT_N   = 4,
  parameter int unsigned ET_W    = 8,
  parameter int unsigned N_THR   = 7,
  parameter int unsigned RATIO_W = 4,
  localparam int unsigned PATCH  = OUT_N + 5,
  localparam int unsigned ROI_N  = PATCH - 1,
  localparam int unsigned SUM2_W = ET_W + 2,
  localparam int unsigned SUM4_W = ET_W + 4,
  localparam int unsigned CODE_W = $clog2(N_THR + 1),
  localparam int unsigned WORD_W = OUT_N * CODE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [PATCH*PATCH*ET_W-1:0]   towers,
  input  logic [N_THR*SUM4_W-1:0]       thr,
  input  logic [RATIO_W-1:0]            iso_num,
  input  logic [RATIO_W-1:0]            iso_den,
  output logic                          res_valid,
  output logic [OUT_N*WORD_W-1:0]       res_codes
);

  // Stage 1: window sums, cluster sums and configuration, captured together.
  logic [ROI_N*ROI_N*SUM2_W-1:0] roi_d, roi_q;
  logic [OUT_N*OUT_N*SUM4_W-1:0] area_d, area_q;
  logic [N_THR*SUM4_W-1:0]       thr_q;
  logic [RATIO_W-1:0]            num_q, den_q;
  logic                          v1_q;

  swc_roi_sum #(.PATCH(PATCH), .ET_W(ET_W)) roi_i (
    .towers_i (towers),
    .roi_o    (roi_d)
  );

  swc_area_sum #(.PATCH(PATCH), .OUT_N(OUT_N), .ET_W(ET_W)) area_i (
    .towers_i (towers),
    .area_o   (area_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      roi_q  <= '0;
      area_q <= '0;
      thr_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        roi_q  <= roi_d;
        area_q <= area_d;
        thr_q  <= thr;
        num_q  <= iso_num;
        den_q  <= iso_den;
      end
    end
  end

  // Stage 2: peak test, isolation, threshold level per output position.
  logic [OUT_N*WORD_W-1:0] code_d;

  for (genvar i = 0; i < OUT_N; i++) begin : g_row
    for (genvar j = 0; j < OUT_N; j++) begin : g_col
      localparam int AR = i + 2;
      localparam int AC = j + 2;
      logic [swc_pkg::NBR_N*SUM2_W-1:0] nbr;

      for (genvar k = 0; k < swc_pkg::NBR_N; k++) begin : g_nbr
        localparam int NR = AR + swc_pkg::nbr_dr(k);
        localparam int NC = AC + swc_pkg::nbr_dc(k);
        assign nbr[k*SUM2_W +: SUM2_W] = roi_q[(NR*ROI_N + NC)*SUM2_W +: SUM2_W];
      end

      swc_peak_judge #(
        .SUM2_W  (SUM2_W),
        .SUM4_W  (SUM4_W),
        .N_THR   (N_THR),
        .RATIO_W (RATIO_W)
      ) judge_i (
        .cand_i (roi_q[(AR*ROI_N + AC)*SUM2_W +: SUM2_W]),
        .nbr_i  (nbr),
        .clus_i (area_q[(i*OUT_N + j)*SUM4_W +: SUM4_W]),
        .thr_i  (thr_q),
        .num_i  (num_q),
        .den_i  (den_q),
        .code_o (code_d[i*WORD_W + j*CODE_W +: CODE_W])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_codes <= '0;
    end else begin
      res_valid <= v1_q;
      if (v1_q) res_codes <= code_d;
    end
  end

endmodule

// File: rtl/swc_cluster_finder_chk.sv
module swc_cluster_finder_chk #(
  parameter int unsigned OUT_N = 4,
  parameter int unsigned N_THR = 7,
  localparam int unsigned CODE_W = $clog2(N_THR + 1),
  localparam int unsigned WORD_W = OUT_N * CODE_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    res_valid,
  input logic [OUT_N*WORD_W-1:0] res_codes
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!res_valid && res_codes == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 res_valid); // R2

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid, 2)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_codes)); // R2

  for (genvar i = 0; i < OUT_N; i++) begin : g_row
    for (genvar j = 0; j < OUT_N; j++) begin : g_col
      localparam int unsigned B = i*WORD_W + j*CODE_W;
      if (j + 1 < OUT_N) begin : g_h
        AST_NO_ADJ_ROW: assert property (@(posedge clk) disable iff (rst)
          !(res_codes[B +: CODE_W] != '0 && res_codes[B+CODE_W +: CODE_W] != '0)); // R5
      end
      if (i + 1 < OUT_N) begin : g_v
        AST_NO_ADJ_COL: assert property (@(posedge clk) disable iff (rst)
          !(res_codes[B +: CODE_W] != '0 && res_codes[B+WORD_W +: CODE_W] != '0)); // R5
      end
      if (i + 1 < OUT_N && j + 1 < OUT_N) begin : g_dr
        AST_NO_ADJ_DIAG: assert property (@(posedge clk) disable iff (rst)
          !(res_codes[B +: CODE_W] != '0 && res_codes[B+WORD_W+CODE_W +: CODE_W] != '0)); // R5
      end
      if (i + 1 < OUT_N && j > 0) begin : g_dl
        AST_NO_ADJ_ANTI: assert property (@(posedge clk) disable iff (rst)
          !(res_codes[B +: CODE_W] != '0 && res_codes[B+WORD_W-CODE_W +: CODE_W] != '0)); // R5
      end
    end
  end

endmodule

bind swc_cluster_finder swc_cluster_finder_chk #(.OUT_N(OUT_N), .N_THR(N_THR)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .res_valid (res_valid),
  .res_codes (res_codes)
);

// File: tb/swc_cluster_finder_tb_top.sv
module swc_cluster_finder_tb_top;

  localparam int OUT_N   = 4;
  localparam int ET_W    = 8;
  localparam int N_THR   = 7;
  localparam int RATIO_W = 4;
  localparam int PATCH   = OUT_N + 5;
  localparam int SUM4_W  = ET_W + 4;
  localparam int CODE_W  = 3;
  localparam int WORD_W  = OUT_N * CODE_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [PATCH*PATCH*ET_W-1:0] towers = '0;
  logic [N_THR*SUM4_W-1:0]     thr = '0;
  logic [RATIO_W-1:0]          iso_num = '0;
  logic [RATIO_W-1:0]          iso_den = '0;
  logic                        res_valid;
  logic [OUT_N*WORD_W-1:0]     res_codes;

  always #10 clk = ~clk;

  swc_cluster_finder #(.OUT_N(OUT_N), .ET_W(ET_W), .N_THR(N_THR), .RATIO_W(RATIO_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .towers    (towers),
    .thr       (thr),
    .iso_num   (iso_num),
    .iso_den   (iso_den),
    .res_valid (res_valid),
    .res_codes (res_codes)
  );

  int checks = 0;
  int fails  = 0;
  int pat [PATCH][PATCH];
  int thr_m [N_THR];
  int num_m = 0;
  int den_m = 1;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int roi_ref(input int r, input int c);
    return pat[r][c] + pat[r+1][c] + pat[r][c+1] + pat[r+1][c+1];
  endfunction

  function automatic int code_ref(input int i, input int j);
    int ar = i + 2;
    int ac = j + 2;
    int cand = roi_ref(ar, ac);
    int clus = 0;
    int code = 0;
    bit pk = 1'b1;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        int n;
        if (dr == 0 && dc == 0) continue;
        n = roi_ref(ar + dr, ac + dc);
        if (dr < 0 || (dr == 0 && dc < 0)) begin
          if (!(cand > n)) pk = 1'b0;
        end else begin
          if (!(cand >= n)) pk = 1'b0;
        end
      end
    end
    for (int r = ar - 1; r <= ar + 2; r++)
      for (int c = ac - 1; c <= ac + 2; c++)
        clus += pat[r][c];
    if (!pk) return 0;
    if (!(cand * den_m > clus * num_m)) return 0;
    for (int k = 0; k < N_THR; k++)
      if (clus >= thr_m[k]) code = k + 1;
    return code;
  endfunction

  task automatic drive_bus();
    for (int r = 0; r < PATCH; r++)
      for (int c = 0; c < PATCH; c++)
        towers[(r*PATCH + c)*ET_W +: ET_W] = ET_W'(pat[r][c]);
    for (int k = 0; k < N_THR; k++) thr[k*SUM4_W +: SUM4_W] = SUM4_W'(thr_m[k]);
    iso_num = RATIO_W'(num_m);
    iso_den = RATIO_W'(den_m);
  endtask

  task automatic clear_pat();
    for (int r = 0; r < PATCH; r++)
      for (int c = 0; c < PATCH; c++)
        pat[r][c] = 0;
  endtask

  task automatic rand_pat();
    for (int r = 0; r < PATCH; r++)
      for (int c = 0; c < PATCH; c++)
        pat[r][c] = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255))
                                                : int'($urandom_range(0, 8));
  endtask

  function automatic int got_code(input int i, input int j);
    return int'(res_codes[i*WORD_W + j*CODE_W +: CODE_W]);
  endfunction

  task automatic run_patch(input string req, input bit scramble);
    int adj;
    @(negedge clk);
    drive_bus();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (scramble) begin
      thr     = '1;
      iso_num = '1;
      iso_den = '0;
    end
    @(negedge clk);
    chk("R2 valid", int'(res_valid), 1);
    for (int i = 0; i < OUT_N; i++)
      for (int j = 0; j < OUT_N; j++)
        chk(req, got_code(i, j), code_ref(i, j));
    adj = 0;
    for (int i = 0; i < OUT_N; i++)
      for (int j = 0; j < OUT_N; j++)
        for (int di = 0; di <= 1; di++)
          for (int dj = -1; dj <= 1; dj++) begin
            if (di == 0 && dj <= 0) continue;
            if (i+di < OUT_N && j+dj >= 0 && j+dj < OUT_N)
              if (got_code(i, j) != 0 && got_code(i+di, j+dj) != 0) adj++;
          end
    chk("R5 touching seeds", adj, 0);
    if (scramble) drive_bus();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [OUT_N*WORD_W-1:0] saved;
    int ratios [6][2];
    ratios = '{'{1,2}, '{1,3}, '{2,3}, '{0,1}, '{1,1}, '{3,4}};
    clear_pat();
    for (int k = 0; k < N_THR; k++) thr_m[k] = 25 * (k + 1);
    num_m = 0;
    den_m = 1;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 valid", int'(res_valid), 0);
    chk("R1 codes", int'(res_codes != '0), 0);
    rst = 1'b0;

    // R3 R4: lone tower swept over every site
    for (int r = 0; r < PATCH; r++)
      for (int c = 0; c < PATCH; c++) begin
        clear_pat();
        pat[r][c] = 200;
        run_patch("R3 R4 lone tower", 1'b0);
      end

    // R4: plateau gives no seed
    for (int r = 0; r < PATCH; r++)
      for (int c = 0; c < PATCH; c++) pat[r][c] = 10;
    run_patch("R4 plateau", 1'b0);
    chk("R4 plateau empty", int'(res_codes != '0), 0);

    // R9: lone tower at (5,4) seeds position (2,1)
    clear_pat();
    pat[5][4] = 200;
    run_patch("R9 model", 1'b0);
    chk("R9 field", int'(res_codes[2*WORD_W + 1*CODE_W +: CODE_W]), 7);
    saved = res_codes;
    saved[2*WORD_W + 1*CODE_W +: CODE_W] = '0;
    chk("R9 other fields", int'(saved != '0), 0);

    // R6: ring tower raises the cluster energy by one level
    for (int k = 0; k < N_THR; k++) thr_m[k] = 40 * (k + 1);
    pat[3][2] = 40;
    run_patch("R6 model", 1'b0);
    chk("R6 ring", int'(res_codes[2*WORD_W + 1*CODE_W +: CODE_W]), 6);

    // R10: full-scale towers, cluster energy 2295
    clear_pat();
    for (int r = 2; r < PATCH; r++)
      for (int c = 2; c < PATCH; c++) pat[r][c] = 255;
    for (int k = 0; k < N_THR; k++) thr_m[k] = 2289 + k;
    num_m = 1;
    den_m = 3;
    run_patch("R10 model", 1'b0);
    chk("R10 full scale", got_code(0, 0), 7);

    // R7: isolation ratio sweep
    for (int k = 0; k < N_THR; k++) thr_m[k] = 30 * (k + 1);
    for (int q = 0; q < 6; q++) begin
      num_m = ratios[q][0];
      den_m = ratios[q][1];
      for (int n = 0; n < 15; n++) begin
        rand_pat();
        run_patch("R7 isolation", 1'b0);
      end
    end

    // R8: unordered thresholds
    num_m = 0;
    den_m = 1;
    for (int n = 0; n < 60; n++) begin
      for (int k = 0; k < N_THR; k++) thr_m[k] = $urandom_range(0, 700);
      rand_pat();
      run_patch("R8 levels", 1'b0);
    end

    // R11: configuration changed after capture
    num_m = 1;
    den_m = 2;
    for (int n = 0; n < 10; n++) begin
      for (int k = 0; k < N_THR; k++) thr_m[k] = 50 * (k + 1);
      rand_pat();
      run_patch("R11 captured config", 1'b1);
    end

    // R2: outputs hold without in_valid
    saved = res_codes;
    rand_pat();
    drive_bus();
    repeat (3) @(negedge clk);
    chk("R2 hold codes", int'(res_codes == saved), 1);
    chk("R2 idle valid", int'(res_valid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule